// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers the interrupt sources of a small microcontroller into a set of request flags, masks them with per-source enable flags and a single global mask flag, and presents the CPU with one interrupt request line plus the 16-bit vector address of the most urgent pending source. Eleven on-chip sources arrive as single-cycle pulses. Two external interrupt pins pass through synchronizers and edge detectors whose active edge software selects. An eight-bit key port is watched for a falling edge of the AND of those pins that are configured as inputs. A software break request from the CPU bypasses all masking.

The CPU reads and writes the flags through a small register window. When it takes the interrupt it pulses an acknowledge strobe. The block then sets the global mask flag and drops the request flag of the source it served. Stacking, vector fetch and instruction sequencing stay in the CPU.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `irq` is high for a hardware source only when that source's request flag and enable flag are both 1 and the global mask flag (register 5 bit 0) is 0.
- R2: Writing register 0 or 1 keeps each request flag whose data bit is 1 and clears each one whose data bit is 0; a write never sets a request flag.
- R3: Request flag k (register 0 bits 7:0 = flags 0..7, register 1 bits 5:0 = flags 8..13) holds, in order: serial receive, serial transmit, external pin 0, external pin 1, key wakeup, counter input 0, counter input 1, timer X, timer Y, timer Z, timer A, second serial port, converter done, timer 1. `pulse_src[j]` feeds flag j for j<2 and flag j+3 otherwise. Flag k takes priority slot k+1 (lower slot wins), and `vector` = 0xFFFC - 2*slot while `irq` is high and 0 while it is low.
- R4: An `ack` pulse while `irq` is high sets the global mask flag and clears the request flag of the served source; an `ack` while `irq` is low changes nothing.
- R5: External pin n (n=0,1) sets flag 2+n on a falling edge when register 4 bit n is 0 and on a rising edge when it is 1, after a two-stage synchronizer; changing that select bit while the pin is steady may itself set the flag.
- R6: The key flag (4) is set when the AND of the `port_pin` bits whose `port_dir` bit is 0 (input) goes from 1 to 0; pins with `port_dir` 1 have no effect, and register 4 bit 2 = 1 blocks the source.
- R7: `brk_req` raises `irq` regardless of any mask flag, with slot 16 (vector 0xFFDC) and the lowest priority; its acknowledge sets the global mask flag and clears no request flag.
- R8: A source event in the same cycle as a software clear or an acknowledge of that flag leaves the flag set.
- R9: After reset all request, enable and control bits are 0 and the global mask flag is 1; register bits without a function, and addresses 6 and 7, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_src | input | 11 | One-cycle event pulses of the on-chip sources |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| port_pin | input | 8 | Asynchronous key port pin levels |
| port_dir | input | 8 | Key port direction, 1 = output |
| brk_req | input | 1 | Software break request, held until acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ack | input | 1 | Interrupt acknowledge strobe from the CPU |
| irq | output | 1 | Interrupt request to the CPU |
| vector | output | 16 | Vector address of the selected source |

## Verification
The priority path is driven first with each on-chip source alone, which shows that every flag lands in its own slot and vector, and then with two sources pending together, which separates a true fixed-order pick from a last-arrival pick. The masking path is tried with the enable off, with the global mask on, and with both open, so that each gate is seen alone. The pin detectors get both edge directions under both select settings plus a select change on a steady pin, and the key detector gets a falling edge on an output pin, on an input pin, and on an input pin with the source blocked. A same-cycle event and clear, a break over a masked and over a pending hardware source, and an acknowledge with nothing pending cover the remaining corners.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NUM_HW    = 14;
    localparam int NUM_PULSE = 11;
    localparam int SLOT_W    = 5;
    localparam int SRC_W     = 4;
    localparam int SLOT_BRK  = 16;
    localparam logic [15:0] VEC_TOP = 16'hFFFC;

    typedef enum logic [SRC_W-1:0] {
        SRC_SRX   = 4'd0,
        SRC_STX   = 4'd1,
        SRC_INT0  = 4'd2,
        SRC_INT1  = 4'd3,
        SRC_KEY   = 4'd4,
        SRC_CNTR0 = 4'd5,
        SRC_CNTR1 = 4'd6,
        SRC_TMX   = 4'd7,
        SRC_TMY   = 4'd8,
        SRC_TMZ   = 4'd9,
        SRC_TMA   = 4'd10,
        SRC_SER2  = 4'd11,
        SRC_ADC   = 4'd12,
        SRC_TM1   = 4'd13
    } src_e;

    typedef enum logic [2:0] {
        RA_REQ_LO = 3'd0,
        RA_REQ_HI = 3'd1,
        RA_EN_LO  = 3'd2,
        RA_EN_HI  = 3'd3,
        RA_CTRL   = 3'd4,
        RA_MASK   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       key_off;
        logic [1:0] edge_rise;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              is_brk;
        logic [SRC_W-1:0]  src;
        logic [SLOT_W-1:0] slot;
    } pick_t;

    function automatic logic [15:0] slot_vector(input logic [SLOT_W-1:0] slot);
        return VEC_TOP - {10'd0, slot, 1'b0};
    endfunction

    // On-chip pulses skip the three flags fed by the pin detectors.
    function automatic int pulse_to_flag(input int j);
        return (j < 2) ? j : j + 3;
    endfunction

endpackage

// File: rtl/ivc_pin_edge.sv
module ivc_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic fire
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic                   active;
    logic                   active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            active_q <= 1'b0;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], pin};
            active_q <= active;
        end
    end

    assign level  = sync_q[SYNC_STAGES-1];
    // Polarity folded in before the edge: a select change can look like an edge.
    assign active = rise_sel ? level : ~level;
    assign fire   = active & ~active_q;

endmodule

// File: rtl/ivc_key_detect.sv
module ivc_key_detect #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port_pin,
    input  logic [PORT_W-1:0] port_dir,
    input  logic              block,
    output logic              fire
);
    logic [SYNC_STAGES-1:0][PORT_W-1:0] sync_q;
    logic                               all_high;
    logic                               all_high_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= '1;
        else     sync_q[0] <= port_pin;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= '1;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    // Output-mode pins are forced high so they never pull the AND down.
    assign all_high = &(sync_q[SYNC_STAGES-1] | port_dir);

    always_ff @(posedge clk) begin
        if (rst) all_high_q <= 1'b0;
        else     all_high_q <= all_high;
    end

    assign fire = all_high_q & ~all_high & ~block;

endmodule

// File: rtl/ivc_priority.sv
module ivc_priority
    import ivc_pkg::*;
#(
    parameter int N = NUM_HW
) (
    input  logic [N-1:0] eligible,
    input  logic         brk,
    output pick_t        pick
);
    always_comb begin
        pick = '0;
        if (brk) begin
            pick.valid  = 1'b1;
            pick.is_brk = 1'b1;
            pick.slot   = SLOT_W'(SLOT_BRK);
        end
        // Descending scan: the last hit, i.e. the lowest index, wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                pick.valid  = 1'b1;
                pick.is_brk = 1'b0;
                pick.src    = SRC_W'(i);
                pick.slot   = SLOT_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int N_EXT       = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PULSE-1:0]  pulse_src,
    input  logic [N_EXT-1:0]      ext_pin,
    input  logic [PORT_W-1:0]     port_pin,
    input  logic [PORT_W-1:0]     port_dir,
    input  logic                  brk_req,
    input  logic                  reg_wr,
    input  logic [2:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  ack,
    output logic                  irq,
    output logic [15:0]           vector
);
    localparam int HI_W = NUM_HW - 8;

    logic [NUM_HW-1:0] req_q, req_d, en_q, keep, set, eligible;
    ctrl_t             ctrl_q;
    logic              mask_q;
    logic [N_EXT-1:0]  ext_fire;
    logic              key_fire;
    logic              accept;
    pick_t             pick;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        ivc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk      (clk),
            .rst      (rst),
            .pin      (ext_pin[g]),
            .rise_sel (ctrl_q.edge_rise[g]),
            .fire     (ext_fire[g])
        );
    end

    ivc_key_detect #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_key (
        .clk      (clk),
        .rst      (rst),
        .port_pin (port_pin),
        .port_dir (port_dir),
        .block    (ctrl_q.key_off),
        .fire     (key_fire)
    );

    always_comb begin
        set = '0;
        for (int j = 0; j < NUM_PULSE; j++) set[pulse_to_flag(j)] = pulse_src[j];
        set[SRC_INT0] = ext_fire[0];
        set[SRC_INT1] = ext_fire[1];
        set[SRC_KEY]  = key_fire;
    end

    assign eligible = mask_q ? '0 : (req_q & en_q);

    ivc_priority #(.N(NUM_HW)) u_pick (
        .eligible (eligible),
        .brk      (brk_req),
        .pick     (pick)
    );

    assign irq    = pick.valid;
    assign vector = pick.valid ? slot_vector(pick.slot) : 16'h0000;
    assign accept = ack & pick.valid;

    always_comb begin
        keep = '1;
        if (reg_wr && reg_addr == RA_REQ_LO) keep[7:0]      = reg_wdata;
        if (reg_wr && reg_addr == RA_REQ_HI) keep[NUM_HW-1:8] = reg_wdata[HI_W-1:0];
        if (accept && !pick.is_brk)          keep[pick.src] = 1'b0;
        // Events are OR-ed in last, so they win over any clear.
        req_d = (req_q & keep) | set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            en_q   <= '0;
            ctrl_q <= '0;
            mask_q <= 1'b1;
        end else begin
            req_q <= req_d;
            if (reg_wr && reg_addr == RA_EN_LO) en_q[7:0] <= reg_wdata;
            if (reg_wr && reg_addr == RA_EN_HI) en_q[NUM_HW-1:8] <= reg_wdata[HI_W-1:0];
            if (reg_wr && reg_addr == RA_CTRL) begin
                ctrl_q.key_off   <= reg_wdata[2];
                ctrl_q.edge_rise <= reg_wdata[1:0];
            end
            if (accept)                          mask_q <= 1'b1;
            else if (reg_wr && reg_addr == RA_MASK) mask_q <= reg_wdata[0];
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_REQ_LO: reg_rdata = req_q[7:0];
            RA_REQ_HI: reg_rdata = {{(8-HI_W){1'b0}}, req_q[NUM_HW-1:8]};
            RA_EN_LO:  reg_rdata = en_q[7:0];
            RA_EN_HI:  reg_rdata = {{(8-HI_W){1'b0}}, en_q[NUM_HW-1:8]};
            RA_CTRL:   reg_rdata = {5'd0, ctrl_q};
            RA_MASK:   reg_rdata = {7'd0, mask_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        brk_req,
    input logic        ack,
    input logic        irq,
    input logic [15:0] vector,
    input logic        mask
);
    // R1: a set global mask silences every hardware source
    a_r1_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (mask && !brk_req) |-> !irq);

    // R7: the break request cannot be masked
    a_r7_brk_unmasked: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> irq);

    // R4: taking an interrupt leaves the global mask set
    a_r4_ack_masks: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> mask);

    // R3: a raised request always points into the even vector window
    a_r3_vec_window: assert property (@(posedge clk) disable iff (rst)
        irq |-> (vector <= 16'hFFFA && vector >= 16'hFFDC && !vector[0]));

    // R3: no request, no vector
    a_r3_idle_vec: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vector == 16'h0000));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .brk_req (brk_req),
    .ack     (ack),
    .irq     (irq),
    .vector  (vector),
    .mask    (mask_q)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] pulse_src = '0;
    logic [1:0]  ext_pin = 2'b11;
    logic [7:0]  port_pin = 8'hFF;
    logic [7:0]  port_dir = 8'hF0;
    logic        brk_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ack = 1'b0;
    logic        irq;
    logic [15:0] vector;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .pulse_src(pulse_src), .ext_pin(ext_pin),
        .port_pin(port_pin), .port_dir(port_dir), .brk_req(brk_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack(ack), .irq(irq), .vector(vector)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int j);
        @(negedge clk);
        pulse_src[j] = 1'b1;
        @(negedge clk);
        pulse_src = '0;
    endtask

    task automatic take();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    function automatic logic [15:0] vec_of(input int slot);
        return 16'hFFFC - 16'(2 * slot);
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R9 reset reg %0d", a), {8'h0, d}, (a == 5) ? 16'h1 : 16'h0);
        end
        check("R9 reset irq", {15'h0, irq}, 16'h0);
        check("R3 idle vector", vector, 16'h0);
        wr(3'd3, 8'hFF);
        rd(3'd3, d);
        check("R9 unused enable bits", {8'h0, d}, 16'h003F);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_accept();
        pulse(0);
        check("R1 enable off", {15'h0, irq}, 16'h0);
        wr(3'd2, 8'h01);
        check("R1 global mask on", {15'h0, irq}, 16'h0);
        wr(3'd5, 8'h00);
        check("R1 both open irq", {15'h0, irq}, 16'h1);
        check("R1 both open vector", vector, 16'hFFFA);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_sw_clear();
        logic [7:0] d;
        pulse(0);
        pulse(1);
        rd(3'd0, d); check("R2 two set", {8'h0, d}, 16'h0003);
        wr(3'd0, 8'hFE);
        rd(3'd0, d); check("R2 clear one", {8'h0, d}, 16'h0002);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R2 write one no set", {8'h0, d}, 16'h0002);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R2 high write no set", {8'h0, d}, 16'h0000);
        wr(3'd0, 8'h00);
        rd(3'd0, d); check("R2 all cleared", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_priority();
        logic [7:0] lo, hi;
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h3F);
        wr(3'd5, 8'h00);
        for (int j = 0; j < 11; j++) begin
            int slot;
            slot = (j < 2) ? j + 1 : j + 4;
            pulse(j);
            check($sformatf("R3 vector of pulse %0d", j), vector, vec_of(slot));
            take();
            rd(3'd0, lo); rd(3'd1, hi);
            check($sformatf("R4 served flag cleared %0d", j), {hi, lo}, 16'h0);
            rd(3'd5, lo);
            check($sformatf("R4 mask set %0d", j), {8'h0, lo}, 16'h1);
            wr(3'd5, 8'h00);
        end
        take();
        rd(3'd5, lo);
        check("R4 ack while idle", {8'h0, lo}, 16'h0);
        pulse(9);
        pulse(5);
        check("R3 two pending pick", vector, 16'hFFEA);
        take();
        wr(3'd5, 8'h00);
        check("R3 next pending", vector, 16'hFFE2);
        take();
        rd(3'd1, hi);
        check("R4 all served", {8'h0, hi}, 16'h0);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        @(negedge clk); ext_pin[0] = 1'b0; idle(4);
        rd(3'd0, d); check("R5 pin0 falling", {8'h0, d}, 16'h0004);
        wr(3'd0, 8'h00);
        @(negedge clk); ext_pin[0] = 1'b1; idle(4);
        rd(3'd0, d); check("R5 pin0 rising ignored", {8'h0, d}, 16'h0000);
        wr(3'd4, 8'h02); idle(2);
        rd(3'd0, d); check("R5 select change fires", {8'h0, d}, 16'h0008);
        wr(3'd0, 8'h00);
        @(negedge clk); ext_pin[1] = 1'b0; idle(4);
        rd(3'd0, d); check("R5 pin1 falling ignored", {8'h0, d}, 16'h0000);
        @(negedge clk); ext_pin[1] = 1'b1; idle(4);
        rd(3'd0, d); check("R5 pin1 rising", {8'h0, d}, 16'h0008);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_key();
        logic [7:0] d;
        @(negedge clk); port_pin[7] = 1'b0; idle(4);
        rd(3'd0, d); check("R6 output pin ignored", {8'h0, d}, 16'h0000);
        @(negedge clk); port_pin[7] = 1'b1; port_pin[1] = 1'b0; idle(4);
        rd(3'd0, d); check("R6 input pin falls", {8'h0, d}, 16'h0010);
        @(negedge clk); port_pin[1] = 1'b1; idle(4);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h06);
        @(negedge clk); port_pin[0] = 1'b0; idle(4);
        rd(3'd0, d); check("R6 blocked source", {8'h0, d}, 16'h0000);
        @(negedge clk); port_pin[0] = 1'b1; idle(4);
    endtask

    task automatic t_brk();
        logic [7:0] d;
        @(negedge clk); brk_req = 1'b1; #1;
        check("R7 break while masked", {15'h0, irq}, 16'h1);
        check("R7 break vector", vector, 16'hFFDC);
        take();
        rd(3'd5, d); check("R7 break ack mask", {8'h0, d}, 16'h1);
        @(negedge clk); brk_req = 1'b0;
        wr(3'd5, 8'h00);
        pulse(4);
        @(negedge clk); brk_req = 1'b1; #1;
        check("R7 hardware beats break", vector, 16'hFFEC);
        @(negedge clk); brk_req = 1'b0;
        take();
        rd(3'd0, d); check("R7 timer flag served", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        pulse(0);
        @(negedge clk);
        pulse_src[1] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
        @(negedge clk);
        pulse_src = '0; reg_wr = 1'b0;
        rd(3'd0, d); check("R8 event beats clear", {8'h0, d}, 16'h0002);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_accept();
        t_sw_clear();
        t_priority();
        t_edges();
        t_key();
        t_brk();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule